// File: doc/BRIEF.md
# Packed BCD Scratchpad Accumulator

This block is the decimal arithmetic slice of an 8-bit accumulator datapath. It holds an accumulator, four status flags, a small scratchpad register file and a scratchpad address register. Each accepted operation is one clock cycle long. Its results show on the outputs after the clock edge that captures the operation.

A packed two-digit decimal sum is formed in two steps. First, software adds the binary bias 0x66 to the accumulator with the immediate-add operation. Then the decimal-add operation adds the scratchpad byte at the current address. Each nibble that did not carry is then corrected: 0xA is added to it, modulo 16. The carry flag holds the decimal carry out.

Decimal subtraction is built from the same operations. The accumulator is complemented, a decimal add brings in the minuend, the bias 0x66 is added again, and a final decimal add of a scratchpad byte holding 0x01 produces the ten's complement difference. Operations that access the scratchpad can step the address up or down afterwards. The step stays inside the low octal digit of the address.

Top module: `bcd_acc_unit`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears the accumulator, all four flags and the address register, whatever else is presented on the inputs.
- R2: Opcode 0 (immediate add) sets the accumulator to (acc + imm) mod 256. Carry is the bit-8 carry, overflow is the two's complement overflow, zero is set when the result is 0x00, and sign is copied from result bit 7.
- R3: Opcode 1 (decimal add) applies to an accumulator already biased with 0x66 and to a valid BCD scratchpad byte. It leaves the packed BCD value (x + y) mod 100 in the accumulator and sets carry exactly when x + y >= 100. Example: 0x42, then add 0x66, then decimal add of 0x83 gives 0x25 with carry set.
- R4: After a decimal add, zero is set when the accumulator is 0x00. Sign equals accumulator bit 7. Overflow is the signed overflow of the uncorrected binary sum.
- R5: Decimal add and scratchpad write both apply the address step after the access. addr_mode 1 adds one and addr_mode 2 subtracts one; both work on address bits [2:0] only, wrap within those bits and leave bits [5:3] unchanged (octal 54 goes to 53, octal 57 goes to 50 on increment). addr_mode 0 and 3 leave the address unchanged.
- R6: Opcode 3 loads the address register from imm[5:0].
- R7: Opcode 4 writes imm into the scratchpad byte at the current address. It leaves the accumulator and flags unchanged.
- R8: Opcode 2 replaces the accumulator with its bitwise complement. It clears carry and overflow and sets zero and sign from the new value.
- R9: Opcode 5 loads imm into the accumulator and leaves the flags unchanged.
- R10: While op_valid is low, and for opcodes 6 and 7, the accumulator, flags and address register do not change.
- R11: Starting from accumulator value a and scratchpad values b and 0x01, both valid BCD, the sequence complement, decimal add of b, immediate add of 0x66, decimal add of 0x01 leaves the BCD value (b - a) mod 100 in the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation strobe; op_sel, addr_mode and imm are captured when high |
| op_sel | input | 3 | Operation: 0 immediate add, 1 decimal add, 2 complement, 3 load address, 4 scratchpad write, 5 load accumulator |
| addr_mode | input | 2 | Address step after a scratchpad access: 0 keep, 1 increment, 2 decrement, 3 keep |
| imm | input | 8 | Immediate byte |
| acc | output | 8 | Accumulator |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag (result bit 7) |
| flag_v | output | 1 | Overflow flag |
| sp_addr | output | 6 | Scratchpad address register |

## Verification
The bench sweeps every pair of two-digit BCD operands, both through the biased decimal add and through the complement-based subtraction sequence. A correction rule that tested the wrong nibble carry, or that rippled a low-nibble correction into the high nibble, would give wrong digits for some of these pairs, for example where the sum is exactly 100 or the difference is zero.

Address stepping is tested where the low octal digit wraps in both directions. A step that carried into bit 3 would show a changed upper digit. Directed cases cover three more faults:
- a zero flag that tests the binary sum instead of the corrected result;
- a complement that keeps a stale carry;
- an idle or unused opcode that still changes state.

// File: rtl/bcd_acc_pkg.sv
// Package: shared widths, opcode and address-step encodings, and the flag
// record of the packed BCD accumulator unit.
package bcd_acc_pkg;

    localparam int DATA_W = 8;               // two packed BCD digits
    localparam int DIGITS = DATA_W / 4;

    typedef enum logic [2:0] {
        OP_ADDI = 3'd0,                      // binary add of immediate
        OP_DADD = 3'd1,                      // decimal add of scratchpad byte
        OP_COMP = 3'd2,                      // bitwise complement of accumulator
        OP_SETA = 3'd3,                      // load scratchpad address
        OP_WRSP = 3'd4,                      // write immediate to scratchpad
        OP_LDA  = 3'd5                       // load accumulator with immediate
    } op_e;

    typedef enum logic [1:0] {
        AM_KEEP  = 2'd0,
        AM_INC   = 2'd1,
        AM_DEC   = 2'd2,
        AM_KEEP3 = 2'd3
    } amode_e;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic v;
    } flags_t;

endpackage

// File: rtl/bcd_corr_adder.sv
// Module: bcd_corr_adder
// One binary adder with per-nibble decimal correction for biased operands.
// Assumes operand a already carries a +6 bias in each nibble. A nibble that
// produced no carry out gets 0xA added (mod 16), which removes the bias.
// Each nibble carry is recovered from the full sum, so the correction
// does not ripple from one nibble to the next.
module bcd_corr_adder #(
    parameter int NDIG = 2
) (
    input  logic [4*NDIG-1:0] a_i,
    input  logic [4*NDIG-1:0] b_i,
    output logic [4*NDIG-1:0] bin_sum_o,
    output logic              carry_o,
    output logic              ovf_o,
    output logic [4*NDIG-1:0] dec_sum_o
);
    localparam int W = 4 * NDIG;

    logic [W:0] a_x;
    logic [W:0] b_x;
    logic [W:0] full;
    logic [W:0] cy_in;                       // carry into each bit position

    // Purpose: widened binary sum and the carry into every bit.
    always_comb begin
        a_x   = {1'b0, a_i};
        b_x   = {1'b0, b_i};
        full  = a_x + b_x;
        cy_in = full ^ a_x ^ b_x;
    end

    assign bin_sum_o = full[W-1:0];
    assign carry_o   = full[W];
    assign ovf_o     = (a_i[W-1] == b_i[W-1]) && (full[W-1] != a_i[W-1]);

    generate
        for (genvar g = 0; g < NDIG; g++) begin : g_nib
            logic       nib_cy;
            logic [3:0] nib_raw;
            // Purpose: undo the bias on a nibble that produced no decimal carry.
            always_comb begin
                nib_cy  = cy_in[4*g+4];
                nib_raw = full[4*g +: 4];
                dec_sum_o[4*g +: 4] = nib_cy ? nib_raw : nib_raw + 4'hA;
            end
        end
    endgenerate

endmodule

// File: rtl/sp_addr_step.sv
// Module: sp_addr_step
// Computes the scratchpad address after an access. The step changes only
// the low LOW_W bits, wraps inside them, and passes the upper bits through.
module sp_addr_step
    import bcd_acc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LOW_W  = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        mode_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [LOW_W-1:0] low_cur;
    logic [LOW_W-1:0] low_nxt;

    // Purpose: step the low digit by the requested amount.
    always_comb begin
        low_cur = addr_i[LOW_W-1:0];
        case (amode_e'(mode_i))
            AM_INC:  low_nxt = low_cur + 1'b1;
            AM_DEC:  low_nxt = low_cur - 1'b1;
            default: low_nxt = low_cur;
        endcase
    end

    generate
        if (LOW_W < ADDR_W) begin : g_split
            assign addr_o = {addr_i[ADDR_W-1:LOW_W], low_nxt};
        end else begin : g_whole
            assign addr_o = low_nxt;
        end
    endgenerate

endmodule

// File: rtl/sp_regfile.sv
// Module: sp_regfile
// Scratchpad byte store with one synchronous write port and one
// asynchronous read port. The contents are not reset: a byte must be
// written before it is read.
module sp_regfile #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [WORD_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Purpose: store a byte on a write strobe.
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/bcd_acc_unit.sv
// Module: bcd_acc_unit (top)
// Accumulator, flags and scratchpad address register of the packed BCD
// unit. One operation is accepted per cycle while op_valid is high, and
// its result is registered at that edge. The immediate add and the decimal
// add share one adder. The decimal add assumes the accumulator was biased
// by +0x66 in the previous step and that both operands are valid BCD.
module bcd_acc_unit
    import bcd_acc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LOW_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_sel,
    input  logic [1:0]        addr_mode,
    input  logic [7:0]        imm,
    output logic [7:0]        acc,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_s,
    output logic              flag_v,
    output logic [ADDR_W-1:0] sp_addr
);
    logic [DATA_W-1:0] acc_q, acc_d;
    flags_t            flg_q, flg_d;
    logic [ADDR_W-1:0] addr_q, addr_d, addr_step;

    op_e               op;
    logic              sp_we;
    logic [DATA_W-1:0] sp_rdata;
    logic [DATA_W-1:0] add_b;
    logic [DATA_W-1:0] bin_sum;
    logic [DATA_W-1:0] dec_sum;
    logic              add_cy;
    logic              add_ovf;
    logic [DATA_W-1:0] acc_inv;

    assign op      = op_e'(op_sel);
    assign sp_we   = op_valid && (op == OP_WRSP);
    assign acc_inv = ~acc_q;

    // Purpose: pick the adder's second operand (scratchpad or immediate).
    always_comb begin
        add_b = (op == OP_DADD) ? sp_rdata : imm;
    end

    sp_regfile #(
        .ADDR_W (ADDR_W),
        .WORD_W (DATA_W)
    ) u_sp (
        .clk     (clk),
        .we_i    (sp_we),
        .waddr_i (addr_q),
        .wdata_i (imm),
        .raddr_i (addr_q),
        .rdata_o (sp_rdata)
    );

    bcd_corr_adder #(
        .NDIG (DIGITS)
    ) u_add (
        .a_i       (acc_q),
        .b_i       (add_b),
        .bin_sum_o (bin_sum),
        .carry_o   (add_cy),
        .ovf_o     (add_ovf),
        .dec_sum_o (dec_sum)
    );

    sp_addr_step #(
        .ADDR_W (ADDR_W),
        .LOW_W  (LOW_W)
    ) u_step (
        .addr_i (addr_q),
        .mode_i (addr_mode),
        .addr_o (addr_step)
    );

    // Purpose: next accumulator and flags for the presented operation.
    always_comb begin
        acc_d = acc_q;
        flg_d = flg_q;
        if (op_valid) begin
            case (op)
                OP_ADDI: begin
                    acc_d = bin_sum;
                    flg_d = '{c: add_cy, z: (bin_sum == '0),
                              s: bin_sum[DATA_W-1], v: add_ovf};
                end
                OP_DADD: begin
                    acc_d = dec_sum;
                    flg_d = '{c: add_cy, z: (dec_sum == '0),
                              s: dec_sum[DATA_W-1], v: add_ovf};
                end
                OP_COMP: begin
                    acc_d = acc_inv;
                    flg_d = '{c: 1'b0, z: (acc_inv == '0),
                              s: acc_inv[DATA_W-1], v: 1'b0};
                end
                OP_LDA: begin
                    acc_d = imm;
                end
                default: begin
                end
            endcase
        end
    end

    // Purpose: next address (load, post-access step, or hold).
    always_comb begin
        addr_d = addr_q;
        if (op_valid) begin
            case (op)
                OP_SETA:          addr_d = imm[ADDR_W-1:0];
                OP_DADD, OP_WRSP: addr_d = addr_step;
                default:          addr_d = addr_q;
            endcase
        end
    end

    // Purpose: state registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            flg_q  <= '0;
            addr_q <= '0;
        end else begin
            acc_q  <= acc_d;
            flg_q  <= flg_d;
            addr_q <= addr_d;
        end
    end

    assign acc     = acc_q;
    assign flag_c  = flg_q.c;
    assign flag_z  = flg_q.z;
    assign flag_s  = flg_q.s;
    assign flag_v  = flg_q.v;
    assign sp_addr = addr_q;

endmodule

// File: rtl/bcd_acc_unit_chk.sv
// Module: bcd_acc_unit_chk
// Port-level properties of bcd_acc_unit, attached through bind.
module bcd_acc_unit_chk
    import bcd_acc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LOW_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        op_sel,
    input logic [1:0]        addr_mode,
    input logic [7:0]        imm,
    input logic [7:0]        acc,
    input logic              flag_c,
    input logic              flag_z,
    input logic              flag_s,
    input logic              flag_v,
    input logic [ADDR_W-1:0] sp_addr
);
    logic [3:0] flv;
    assign flv = {flag_c, flag_z, flag_s, flag_v};

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (acc == 8'h00 && sp_addr == '0 && flv == 4'h0));

    assert_addi_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_ADDI) |=>
        ({flag_c, acc} == ({1'b0, $past(acc)} + {1'b0, $past(imm)})));

    assert_dadd_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_DADD) |=>
        (flag_z == (acc == 8'h00) && flag_s == acc[7]));

    assert_step_upper_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == OP_DADD || op_sel == OP_WRSP)) |=>
        (sp_addr[ADDR_W-1:LOW_W] == $past(sp_addr[ADDR_W-1:LOW_W])));

    assert_step_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_WRSP && addr_mode == AM_INC) |=>
        (sp_addr[LOW_W-1:0] == LOW_W'($past(sp_addr[LOW_W-1:0]) + 1'b1)));

    assert_setaddr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_SETA) |=> (sp_addr == $past(imm[ADDR_W-1:0])));

    assert_write_keeps_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_WRSP) |=> ($stable(acc) && $stable(flv)));

    assert_complement_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_COMP) |=>
        (acc == ~$past(acc) && !flag_c && !flag_v));

    assert_load_acc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_LDA) |=> (acc == $past(imm) && $stable(flv)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_sel == 3'd6 || op_sel == 3'd7) |=>
        ($stable(acc) && $stable(flv) && $stable(sp_addr)));

endmodule

bind bcd_acc_unit bcd_acc_unit_chk #(
    .ADDR_W (ADDR_W),
    .LOW_W  (LOW_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_sel    (op_sel),
    .addr_mode (addr_mode),
    .imm       (imm),
    .acc       (acc),
    .flag_c    (flag_c),
    .flag_z    (flag_z),
    .flag_s    (flag_s),
    .flag_v    (flag_v),
    .sp_addr   (sp_addr)
);

// File: tb/bcd_acc_unit_tb.sv
// Bench for bcd_acc_unit. Inputs change on the falling edge and outputs are
// sampled on the next falling edge, one cycle after capture.
module bcd_acc_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    localparam logic [2:0] ADDI = 3'd0, DADD = 3'd1, COMP = 3'd2,
                           SETA = 3'd3, WRSP = 3'd4, LDA = 3'd5;
    localparam logic [1:0] KEEP = 2'd0, INC = 2'd1, DEC = 2'd2, KEEP3 = 2'd3;

    typedef struct packed {
        logic [3:0] req;
        logic [2:0] op;
        logic [1:0] mode;
        logic [7:0] val;
        logic [7:0] e_acc;
        logic       e_c;
        logic [5:0] e_addr;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{4'd6,  SETA, KEEP,  8'h2C, 8'h00, 1'b0, 6'h2C},  // octal 54
        '{4'd7,  WRSP, KEEP,  8'h83, 8'h00, 1'b0, 6'h2C},
        '{4'd9,  LDA,  KEEP,  8'h42, 8'h42, 1'b0, 6'h2C},
        '{4'd2,  ADDI, KEEP,  8'h66, 8'hA8, 1'b0, 6'h2C},
        '{4'd3,  DADD, DEC,   8'h00, 8'h25, 1'b1, 6'h2B},  // 42+83, octal 53
        '{4'd6,  SETA, KEEP,  8'h28, 8'h25, 1'b1, 6'h28},
        '{4'd5,  WRSP, DEC,   8'h99, 8'h25, 1'b1, 6'h2F},  // 50 -> 57
        '{4'd5,  WRSP, INC,   8'h01, 8'h25, 1'b1, 6'h28},  // 57 -> 50
        '{4'd9,  LDA,  KEEP,  8'h00, 8'h00, 1'b1, 6'h28},
        '{4'd2,  ADDI, KEEP,  8'h66, 8'h66, 1'b0, 6'h28},
        '{4'd6,  SETA, KEEP,  8'h2F, 8'h66, 1'b0, 6'h2F},
        '{4'd5,  DADD, KEEP3, 8'h00, 8'h01, 1'b0, 6'h2F},  // 0+1, mode 3 keeps
        '{4'd2,  ADDI, KEEP,  8'hFF, 8'h00, 1'b1, 6'h2F},
        '{4'd8,  COMP, KEEP,  8'h00, 8'hFF, 1'b0, 6'h2F},
        '{4'd6,  SETA, KEEP,  8'h07, 8'hFF, 1'b0, 6'h07},
        '{4'd5,  WRSP, INC,   8'h55, 8'hFF, 1'b0, 6'h00},  // 07 -> 00
        '{4'd10, 3'd6, INC,   8'h12, 8'hFF, 1'b0, 6'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [1:0] addr_mode = 2'd0;
    logic [7:0] imm = 8'h00;
    logic [7:0] acc;
    logic       flag_c, flag_z, flag_s, flag_v;
    logic [5:0] sp_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bcd_acc_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_sel    (op_sel),
        .addr_mode (addr_mode),
        .imm       (imm),
        .acc       (acc),
        .flag_c    (flag_c),
        .flag_z    (flag_z),
        .flag_s    (flag_s),
        .flag_v    (flag_v),
        .sp_addr   (sp_addr)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Called on a falling edge; returns on the next one with results visible.
    task automatic do_op(input logic [2:0] o, input logic [1:0] m, input logic [7:0] v);
        op_valid  = 1'b1;
        op_sel    = o;
        addr_mode = m;
        imm       = v;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        op_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset acc", 32'(acc), 32'h00);
        check("R1 reset flags", 32'({flag_c, flag_z, flag_s, flag_v}), 32'h0);
        check("R1 reset addr", 32'(sp_addr), 32'h00);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            do_op(VECS[i].op, VECS[i].mode, VECS[i].val);
            check($sformatf("R%0d vec %0d acc", VECS[i].req, i), 32'(acc), 32'(VECS[i].e_acc));
            check($sformatf("R%0d vec %0d carry", VECS[i].req, i), 32'(flag_c), 32'(VECS[i].e_c));
            check($sformatf("R%0d vec %0d addr", VECS[i].req, i), 32'(sp_addr), 32'(VECS[i].e_addr));
        end

        // R4: flags after decimal add (order c z s v)
        do_op(SETA, KEEP, 8'h30);
        do_op(WRSP, KEEP, 8'h50);
        do_op(LDA, KEEP, 8'h50);
        do_op(ADDI, KEEP, 8'h66);
        do_op(DADD, KEEP, 8'h00);
        check("R4 50+50 acc", 32'(acc), 32'h00);
        check("R4 50+50 flags", 32'({flag_c, flag_z, flag_s, flag_v}), 32'b1100);
        do_op(WRSP, KEEP, 8'h45);
        do_op(LDA, KEEP, 8'h45);
        do_op(ADDI, KEEP, 8'h66);
        do_op(DADD, KEEP, 8'h00);
        check("R4 45+45 acc", 32'(acc), 32'h90);
        check("R4 45+45 flags", 32'({flag_c, flag_z, flag_s, flag_v}), 32'b0010);
        do_op(WRSP, KEEP, 8'h83);
        do_op(LDA, KEEP, 8'h42);
        do_op(ADDI, KEEP, 8'h66);
        do_op(DADD, KEEP, 8'h00);
        check("R4 42+83 overflow", 32'(flag_v), 32'h1);
        // R8: complement of 0xFF sets zero
        do_op(LDA, KEEP, 8'hFF);
        do_op(COMP, KEEP, 8'h00);
        check("R8 comp zero", 32'({acc, flag_c, flag_z, flag_s, flag_v}), {24'h0, 8'h00, 4'b0100});

        // R10: strobe low ignores a presented load
        op_valid  = 1'b0;
        op_sel    = LDA;
        imm       = 8'h33;
        addr_mode = INC;
        repeat (3) @(negedge clk);
        check("R10 idle acc", 32'(acc), 32'h00);
        check("R10 idle addr", 32'(sp_addr), 32'h30);
        do_op(3'd7, INC, 8'h77);
        check("R10 opcode7 acc", 32'(acc), 32'h00);
        check("R10 opcode7 addr", 32'(sp_addr), 32'h30);

        // R3 and R11: all BCD operand pairs
        do_op(SETA, KEEP, 8'h11);
        do_op(WRSP, KEEP, 8'h01);
        for (int b = 0; b < 100; b++) begin
            do_op(SETA, KEEP, 8'h10);
            do_op(WRSP, KEEP, to_bcd(b));
            for (int a = 0; a < 100; a++) begin
                do_op(LDA, KEEP, to_bcd(a));
                do_op(ADDI, KEEP, 8'h66);
                do_op(DADD, KEEP, 8'h00);
                check($sformatf("R3 %0d+%0d", a, b), 32'({flag_c, acc}),
                      32'({(a + b) >= 100, to_bcd((a + b) % 100)}));
                do_op(LDA, KEEP, to_bcd(a));
                do_op(COMP, KEEP, 8'h00);
                do_op(DADD, INC, 8'h00);
                do_op(ADDI, KEEP, 8'h66);
                do_op(DADD, DEC, 8'h00);
                check($sformatf("R11 %0d-%0d", b, a), 32'(acc),
                      32'(to_bcd((b - a + 100) % 100)));
            end
        end

        // R1: reset wins over a strobed load
        rst_n = 1'b0;
        do_op(LDA, KEEP, 8'h77);
        check("R1 reset over op acc", 32'(acc), 32'h00);
        check("R1 reset over op addr", 32'(sp_addr), 32'h00);
        rst_n = 1'b1;
        idle(2);
        finish_run();
    end

endmodule